// File: doc/BRIEF.md
# Shadow Register Commit Unit

This block sits between configuration registers that are loaded over a serial control port and logic that runs on a separate reference clock. Some parameters, such as the integer and fractional words of a synthesizer feedback divider, span several registers and need several serial cycles to load. If each register reached the controlled logic as soon as it was written, that logic would see a mix of old and new words while loading was still in progress. This unit prevents that by holding a bank of applied copies of the configuration fields.

The serial enable (active low during a transaction) is resynchronised into the reference clock domain. The applied copies keep their previous contents for the whole transaction. When the enable returns high, a single commit pulse loads every field in the same reference cycle. After that the outputs hold again until the next completed transaction. The register side keeps its values stable while the enable is high, so the multi-bit words are sampled directly on the commit pulse without a crossing of their own.

There is no streaming data path. All pins are plain level signals, and the applied values are always valid.

Top module: `shadow_commit_unit`

## Requirements
- R1: While `ref_rst_n` is low, and from its release until the first commit, every field of `applied_out` equals the `RESET_VAL` parameter.
- R2: While `sen_n` is low, changes on `cfg_in` do not appear on `applied_out`.
- R3: With the default `SYNC_STAGES` of 2, a rising edge of `sen_n` makes `applied_out` equal `cfg_in` on the third rising `ref_clk` edge after the transition.
- R4: `applied_out` keeps its old value up to and including the second rising edge after `sen_n` rises, so the update never happens early.
- R5: While `sen_n` stays high, changes on `cfg_in` have no effect on `applied_out`.
- R6: Each low-then-high transaction of `sen_n` produces exactly one commit, and back-to-back transactions each commit their own data.
- R7: If `sen_n` is high when reset is released, no commit takes place until `sen_n` has gone low and high again.
- R8: Field i occupies bits `[i*FIELD_W +: FIELD_W]` of both `cfg_in` and `applied_out`. All fields are loaded in the same cycle, and each field takes only its own slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that drives the applied copies |
| ref_rst_n | input | 1 | Asynchronous active-low reset, reference domain |
| sen_n | input | 1 | Serial enable, asynchronous; low during a transaction |
| cfg_in | input | NUM_FIELDS*FIELD_W | Register-side field values, packed by field index |
| applied_out | output | NUM_FIELDS*FIELD_W | Applied field values seen by the controlled logic |

## Verification
The bench changes `cfg_in` in three situations: while the enable is low, while it stays high, and across the rising edge of the enable. Together these separate three kinds of fault: a bank that follows its input transparently, one that commits on a level instead of an edge, and one that commits a cycle early or late. The update cycle is checked on both sides, one edge before and at the exact edge. Back-to-back transactions check that each commit takes fresh data. Releasing reset with the enable high checks that reset alone produces no commit. A pattern with a different value in every field shows that a slice swap or a partial load would be seen.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  parameter int unsigned DEF_NUM_FIELDS = 4;
  parameter int unsigned DEF_FIELD_W    = 16;
  parameter int unsigned MIN_SYNC       = 2;

  function automatic int unsigned sync_depth(input int unsigned req);
    return (req < MIN_SYNC) ? MIN_SYNC : req;
  endfunction
endpackage

// File: rtl/sen_commit_sync.sv
module sen_commit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sen_async,
  output logic commit
);
  localparam int unsigned DEPTH = shadow_pkg::sync_depth(STAGES);

  logic [DEPTH-1:0] chain;
  logic             prev;

  // Synchroniser resets to idle-high, so releasing reset never looks like a rising edge.
  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= sen_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[DEPTH-1];
  end

  assign commit = chain[DEPTH-1] & ~prev;
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int unsigned                        NUM_FIELDS = 4,
  parameter int unsigned                        FIELD_W    = 16,
  parameter logic [NUM_FIELDS*FIELD_W-1:0]      RESET_VAL  = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [NUM_FIELDS*FIELD_W-1:0] src,
  output logic [NUM_FIELDS*FIELD_W-1:0] dst
);
  generate
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      logic [FIELD_W-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold_q <= RESET_VAL[f*FIELD_W +: FIELD_W];
        else if (load) hold_q <= src[f*FIELD_W +: FIELD_W];
      end
      assign dst[f*FIELD_W +: FIELD_W] = hold_q;
    end
  endgenerate
endmodule

// File: rtl/shadow_commit_unit.sv
module shadow_commit_unit #(
  parameter int unsigned                   NUM_FIELDS  = shadow_pkg::DEF_NUM_FIELDS,
  parameter int unsigned                   FIELD_W     = shadow_pkg::DEF_FIELD_W,
  parameter int unsigned                   SYNC_STAGES = 2,
  parameter logic [NUM_FIELDS*FIELD_W-1:0] RESET_VAL   = '0
) (
  input  logic                          ref_clk,
  input  logic                          ref_rst_n,
  input  logic                          sen_n,
  input  logic [NUM_FIELDS*FIELD_W-1:0] cfg_in,
  output logic [NUM_FIELDS*FIELD_W-1:0] applied_out
);
  logic commit_pulse;

  sen_commit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (ref_clk),
    .rst_n    (ref_rst_n),
    .sen_async(sen_n),
    .commit   (commit_pulse)
  );

  shadow_bank #(
    .NUM_FIELDS(NUM_FIELDS),
    .FIELD_W   (FIELD_W),
    .RESET_VAL (RESET_VAL)
  ) u_bank (
    .clk  (ref_clk),
    .rst_n(ref_rst_n),
    .load (commit_pulse),
    .src  (cfg_in),
    .dst  (applied_out)
  );
endmodule

// File: rtl/shadow_commit_chk.sv
module shadow_commit_chk #(
  parameter int unsigned                   NUM_FIELDS = 4,
  parameter int unsigned                   FIELD_W    = 16,
  parameter logic [NUM_FIELDS*FIELD_W-1:0] RESET_VAL  = '0
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          commit,
  input logic [NUM_FIELDS*FIELD_W-1:0] cfg,
  input logic [NUM_FIELDS*FIELD_W-1:0] applied
);
  // R2, R5: without a commit the applied bank does not move
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(applied));

  // R3, R8: a commit loads every field from the register side at once
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (applied == $past(cfg)));

  // R6: a commit lasts one cycle only
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R1, R7: right after reset release the defaults are present and no commit is pending
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (applied == RESET_VAL) && !commit);
endmodule

bind shadow_commit_unit shadow_commit_chk #(
  .NUM_FIELDS(NUM_FIELDS),
  .FIELD_W   (FIELD_W),
  .RESET_VAL (RESET_VAL)
) u_chk (
  .clk    (ref_clk),
  .rst_n  (ref_rst_n),
  .commit (commit_pulse),
  .cfg    (cfg_in),
  .applied(applied_out)
);

// File: tb/shadow_commit_unit_bench.sv
module shadow_commit_unit_bench;
  localparam int unsigned NF = 4;
  localparam int unsigned FW = 16;
  localparam logic [NF*FW-1:0] RV = 64'h0123_4567_89AB_CDEF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sen_n = 1'b1;
  logic [NF*FW-1:0] cfg = '0;
  logic [NF*FW-1:0] app;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shadow_commit_unit #(.NUM_FIELDS(NF), .FIELD_W(FW), .SYNC_STAGES(2), .RESET_VAL(RV))
    u_shadow_commit_unit (
      .ref_clk(clk), .ref_rst_n(rst_n), .sen_n(sen_n), .cfg_in(cfg), .applied_out(app));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [NF*FW-1:0] exp, input string tag);
    checks++;
    if (app !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, app, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sen_n = 1'b1; cfg = 64'hFFFF_0000_FFFF_0000;
    step(2);
    check(RV, "R1 during reset");
    rst_n = 1'b1;
    step(4);
    check(RV, "R1 after release");
  endtask

  task automatic t_latency;
    sen_n = 1'b0;
    cfg = 64'h1111_2222_3333_4444;
    step(3);
    check(RV, "R2 low enable blocks update");
    cfg = 64'hAAAA_BBBB_CCCC_DDDD;
    step(2);
    check(RV, "R2 low enable second word");
    sen_n = 1'b1;
    step(1);
    check(RV, "R4 first edge after rise");
    step(1);
    check(RV, "R4 second edge after rise");
    step(1);
    check(64'hAAAA_BBBB_CCCC_DDDD, "R3 third edge commit");
  endtask

  task automatic t_high_ignored;
    cfg = 64'h5555_6666_7777_8888;
    step(6);
    check(64'hAAAA_BBBB_CCCC_DDDD, "R5 change while enable high");
  endtask

  task automatic t_back_to_back;
    sen_n = 1'b0; cfg = 64'h0C0C_0C0C_0C0C_0C0C;
    step(2);
    sen_n = 1'b1;
    step(3);
    check(64'h0C0C_0C0C_0C0C_0C0C, "R6 first transaction");
    sen_n = 1'b0; cfg = 64'h0D0D_0D0D_0D0D_0D0D;
    step(2);
    sen_n = 1'b1;
    step(3);
    check(64'h0D0D_0D0D_0D0D_0D0D, "R6 second transaction");
    cfg = 64'h0E0E_0E0E_0E0E_0E0E;
    step(5);
    check(64'h0D0D_0D0D_0D0D_0D0D, "R6 no extra commit");
  endtask

  task automatic t_reset_high;
    cfg = 64'hBEEF_BEEF_BEEF_BEEF;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(6);
    check(RV, "R7 no commit from reset with enable high");
    sen_n = 1'b0;
    step(2);
    sen_n = 1'b1;
    step(3);
    check(64'hBEEF_BEEF_BEEF_BEEF, "R7 commit after real transaction");
  endtask

  task automatic t_fields;
    logic [NF*FW-1:0] pat;
    for (int f = 0; f < NF; f++) pat[f*FW +: FW] = 16'hF000 + 16'(f * 16'h0111);
    sen_n = 1'b0; cfg = pat;
    step(2);
    sen_n = 1'b1;
    step(3);
    for (int f = 0; f < NF; f++) begin
      checks++;
      if (app[f*FW +: FW] !== pat[f*FW +: FW]) begin
        errors++;
        $display("FAIL R8 field %0d: actual=%h expected=%h", f, app[f*FW +: FW], pat[f*FW +: FW]);
      end
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_high_ignored();
    t_back_to_back();
    t_reset_high();
    t_fields();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule